// File: doc/BRIEF.md
# DHCP Lease Countdown Timer

This block keeps track of how long a network controller may still use its leased IP address. When a lease is granted, the controller pulses a load strobe together with the lease length in seconds. The block then counts the seconds down. Halfway through the lease it sends a one-cycle renewal request. When the count reaches zero it raises a sticky expired flag. A link-down input drops the timer back to idle at any moment. The packet exchange itself happens elsewhere.

The one-second timebase does not use a wide binary prescaler. It uses a maximal-length Galois LFSR. The LFSR is seeded with a known value, and the block watches for the single state the LFSR reaches after one second's worth of steps minus one. That state is computed at elaboration by a polynomial-power function in the package. When the LFSR reaches it, the LFSR is reseeded. A small binary counter then holds only the whole seconds. With the defaults (100 MHz, 27-bit LFSR, 86400 s ceiling) the seconds counter is 17 bits wide.

`LFSR_W` must be one of 5, 8, 16, 27 or 32. `CYCLES_PER_SEC` must not exceed 2^`LFSR_W` − 1. In the text below, N stands for `CYCLES_PER_SEC`.

Top module: `lease_timer`

## Requirements
- R1: During and after reset, `expired_o` is 1 and `renew_o` is 0.
- R2: Suppose `load_i` is high, with `link_down_i` low, at clock edge k, and the lease is nonzero. Then `expired_o` is 0 from edge k and rises at edge k + L·N. L is the clamped lease.
- R3: For such a load, `renew_o` is high for exactly one cycle, starting at edge k + (L − floor(L/2))·N, when floor(L/2) ≥ 1. No renewal pulse occurs when L = 1.
- R4: `lease_i` is a 32-bit unsigned number of seconds. Values above `MAX_LEASE` are treated as `MAX_LEASE`.
- R5: Loading a lease of 0 leaves `expired_o` at 1 and produces no renewal pulse.
- R6: A load while a lease is counting discards the old schedule. Both the sub-second phase and the seconds restart from the new load edge.
- R7: `link_down_i` high at an edge sets `expired_o` to 1 and `renew_o` to 0 after that edge. It cancels any pending renewal or expiry. It overrides a simultaneous `load_i`.
- R8: Once expired or idle, `expired_o` stays 1 and `renew_o` stays 0 until the next accepted load.
- R9: The LFSR never holds the all-zero state. The second tick occurs exactly every N cycles after the LFSR is seeded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| link_down_i | input | 1 | Link lost: return to idle, with the expired flag set |
| load_i | input | 1 | Single-cycle strobe: start a new lease |
| lease_i | input | 32 | Granted lease in seconds, sampled with `load_i` |
| renew_o | output | 1 | One-cycle renewal request at half lease |
| expired_o | output | 1 | High while no lease is valid |

## Verification
The hardest situation to reach is the LFSR matching its precomputed terminal state. At default parameters this happens only once every hundred million cycles. The bench therefore instantiates the block with a 5-bit LFSR and a ten-cycle second, so the same jump function and the same match logic run many times. From there, the stimulus reloads the timer and drops the link partway through a second. It also drops the link between the renewal pulse and expiry. This shows that a restart really resets the sub-second phase and does not just reset the seconds.

// File: rtl/lease_pkg.sv
package lease_pkg;

  // Low-order feedback bits of a primitive polynomial for supported widths.
  function automatic logic [31:0] poly_low(input int unsigned w);
    case (w)
      5:       return 32'h0000_0009;
      8:       return 32'h0000_0071;
      16:      return 32'h0000_A011;
      27:      return 32'h0000_0027;
      32:      return 32'h0040_0007;
      default: return 32'h0000_0000;
    endcase
  endfunction

  // Multiply by x modulo P(x): one Galois LFSR step.
  function automatic logic [31:0] gf_xtime(input logic [31:0] a,
                                           input int unsigned w,
                                           input logic [31:0] low);
    logic [32:0] t;
    t = {a, 1'b0};
    if (t[w]) t = t ^ {1'b0, low};
    t[w] = 1'b0;
    return t[31:0];
  endfunction

  function automatic logic [31:0] gf_mul(input logic [31:0] a,
                                         input logic [31:0] b,
                                         input int unsigned w,
                                         input logic [31:0] low);
    logic [31:0] r;
    r = '0;
    for (int i = 31; i >= 0; i--) begin
      r = gf_xtime(r, w, low);
      if (b[i]) r = r ^ a;
    end
    return r;
  endfunction

  // State reached from seed after k steps: seed * x^k mod P(x).
  function automatic logic [31:0] lfsr_jump(input logic [31:0] seed,
                                            input logic [31:0] k,
                                            input int unsigned w);
    logic [31:0] low, acc, base;
    low  = poly_low(w);
    acc  = 32'd1;
    base = 32'd2;
    for (int i = 0; i < 32; i++) begin
      if (k[i]) acc = gf_mul(acc, base, w, low);
      base = gf_mul(base, base, w, low);
    end
    return gf_mul(seed, acc, w, low);
  endfunction

  function automatic logic [31:0] clamp_lease(input logic [31:0] lease,
                                              input logic [31:0] ceiling);
    return (lease > ceiling) ? ceiling : lease;
  endfunction

endpackage

// File: rtl/lfsr_sec_prescaler.sv
module lfsr_sec_prescaler #(
  parameter int unsigned LFSR_W         = 27,
  parameter int unsigned CYCLES_PER_SEC = 100_000_000,
  parameter logic [31:0] SEED           = 32'd1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart_i,
  input  logic run_i,
  output logic tick_o
);
  localparam logic [LFSR_W-1:0] POLY     = LFSR_W'(lease_pkg::poly_low(LFSR_W));
  localparam logic [LFSR_W-1:0] SEED_W   = LFSR_W'(SEED);
  localparam logic [LFSR_W-1:0] TERMINAL =
    LFSR_W'(lease_pkg::lfsr_jump(SEED, 32'(CYCLES_PER_SEC - 1), LFSR_W));

  logic [LFSR_W-1:0] lfsr_q, lfsr_step;

  assign lfsr_step = {lfsr_q[LFSR_W-2:0], 1'b0} ^ (lfsr_q[LFSR_W-1] ? POLY : '0);
  assign tick_o    = run_i && (lfsr_q == TERMINAL);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                            lfsr_q <= SEED_W;
    else if (restart_i || tick_o || !run_i) lfsr_q <= SEED_W;
    else                                   lfsr_q <= lfsr_step;
  end

  // Observation counter for the period check only.
  logic [31:0] since_seed_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                            since_seed_q <= '0;
    else if (restart_i || tick_o || !run_i) since_seed_q <= '0;
    else                                   since_seed_q <= since_seed_q + 32'd1;
  end

  AST_LFSR_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    lfsr_q != '0); // R9
  AST_TICK_PERIOD: assert property (@(posedge clk) disable iff (!rst_n)
    run_i |-> (tick_o == (since_seed_q == 32'(CYCLES_PER_SEC - 1)))); // R9

endmodule

// File: rtl/lease_sec_counter.sv
module lease_sec_counter #(
  parameter int unsigned MAX_LEASE = 86400,
  parameter int unsigned SEC_W     = 17
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear_i,
  input  logic             load_i,
  input  logic [SEC_W-1:0] lease_sat_i,
  input  logic             tick_i,
  output logic             running_o,
  output logic             renew_o,
  output logic             expired_o
);
  logic [SEC_W-1:0] secs_q, thr_q, secs_dec;
  logic             running_q, renew_q, expired_q;

  assign secs_dec = secs_q - 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      secs_q <= '0; thr_q <= '0; running_q <= 1'b0; expired_q <= 1'b1; renew_q <= 1'b0;
    end else if (clear_i) begin
      secs_q <= '0; thr_q <= '0; running_q <= 1'b0; expired_q <= 1'b1; renew_q <= 1'b0;
    end else if (load_i) begin
      secs_q    <= lease_sat_i;
      thr_q     <= lease_sat_i >> 1;
      running_q <= (lease_sat_i != '0);
      expired_q <= (lease_sat_i == '0);
      renew_q   <= 1'b0;
    end else begin
      renew_q <= 1'b0;
      if (running_q && tick_i) begin
        secs_q <= secs_dec;
        if (secs_dec == '0) begin
          running_q <= 1'b0;
          expired_q <= 1'b1;
        end
        if (secs_dec == thr_q && thr_q != '0) renew_q <= 1'b1;
      end
    end
  end

  assign running_o = running_q;
  assign renew_o   = renew_q;
  assign expired_o = expired_q;

  AST_RENEW_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    renew_q |=> !renew_q); // R3
  AST_CLEAR_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    clear_i |=> (expired_q && !renew_q && !running_q)); // R7
  AST_EXPIRED_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (expired_q && !load_i) |=> expired_q); // R8
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !running_q |=> !renew_q); // R8
  AST_SECS_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    secs_q <= SEC_W'(MAX_LEASE)); // R4
  AST_RUN_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    running_q != expired_q); // R5

endmodule

// File: rtl/lease_timer.sv
module lease_timer #(
  parameter int unsigned CYCLES_PER_SEC = 100_000_000,
  parameter int unsigned LFSR_W         = 27,
  parameter int unsigned MAX_LEASE      = 86400,
  parameter logic [31:0] SEED           = 32'd1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        link_down_i,
  input  logic        load_i,
  input  logic [31:0] lease_i,
  output logic        renew_o,
  output logic        expired_o
);
  localparam int unsigned SEC_W = $clog2(MAX_LEASE + 1);

  logic             sec_tick;
  logic             timer_running;
  logic             restart;
  logic [SEC_W-1:0] lease_sat;

  assign restart   = load_i || link_down_i;
  assign lease_sat = SEC_W'(lease_pkg::clamp_lease(lease_i, 32'(MAX_LEASE)));

  lfsr_sec_prescaler #(
    .LFSR_W(LFSR_W), .CYCLES_PER_SEC(CYCLES_PER_SEC), .SEED(SEED)
  ) i_prescaler (
    .clk(clk), .rst_n(rst_n), .restart_i(restart),
    .run_i(timer_running), .tick_o(sec_tick)
  );

  lease_sec_counter #(
    .MAX_LEASE(MAX_LEASE), .SEC_W(SEC_W)
  ) i_counter (
    .clk(clk), .rst_n(rst_n), .clear_i(link_down_i), .load_i(load_i),
    .lease_sat_i(lease_sat), .tick_i(sec_tick), .running_o(timer_running),
    .renew_o(renew_o), .expired_o(expired_o)
  );

  AST_RENEW_NOT_EXPIRED: assert property (@(posedge clk) disable iff (!rst_n)
    !(renew_o && expired_o)); // R3

endmodule

// File: tb/test_lease_timer.sv
module test_lease_timer;
  localparam int N   = 10;
  localparam int MAX = 40;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        link_down_i = 1'b0;
  logic        load_i = 1'b0;
  logic [31:0] lease_i = '0;
  logic        renew_o, expired_o;

  int checks = 0;
  int fails  = 0;
  string tag = "R1";

  always #5 clk = ~clk;

  lease_timer #(.CYCLES_PER_SEC(N), .LFSR_W(5), .MAX_LEASE(MAX), .SEED(32'd1)) i_lease_timer (
    .clk(clk), .rst_n(rst_n), .link_down_i(link_down_i), .load_i(load_i),
    .lease_i(lease_i), .renew_o(renew_o), .expired_o(expired_o)
  );

  // Behavioural reference: cycle countdowns to the two events.
  bit     m_exp = 1'b1;
  bit     m_ren = 1'b0;
  bit     m_run = 1'b0;
  longint exp_left = 0;
  longint ren_left = -1;
  int     renew_seen = 0;

  always @(posedge clk) begin
    longint lsat;
    if (!rst_n || link_down_i) begin
      m_exp = 1; m_ren = 0; m_run = 0; exp_left = 0; ren_left = -1;
    end else if (load_i) begin
      lsat  = (lease_i > MAX) ? MAX : lease_i;
      m_ren = 0;
      m_run = (lsat != 0);
      m_exp = (lsat == 0);
      exp_left = lsat * N;
      ren_left = (lsat / 2 >= 1) ? (lsat - lsat / 2) * N : -1;
    end else begin
      m_ren = 0;
      if (m_run) begin
        exp_left--;
        if (ren_left > 0) ren_left--;
        if (ren_left == 0) begin m_ren = 1; ren_left = -1; end
        if (exp_left == 0) begin m_exp = 1; m_run = 0; end
      end
    end
  end

  always @(negedge clk) begin
    checks++;
    if (expired_o !== m_exp) begin
      fails++;
      $display("FAIL %s expired_o actual=%b expected=%b at %0t", tag, expired_o, m_exp, $time);
    end
    checks++;
    if (renew_o !== m_ren) begin
      fails++;
      $display("FAIL %s renew_o actual=%b expected=%b at %0t", tag, renew_o, m_ren, $time);
    end
    if (renew_o) renew_seen++;
  end

  task automatic do_load(input logic [31:0] v);
    @(negedge clk); load_i = 1'b1; lease_i = v;
    @(negedge clk); load_i = 1'b0;
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic count_check(input string t, input int exp_n);
    checks++;
    if (renew_seen != exp_n) begin
      fails++;
      $display("FAIL %s renewal count actual=%0d expected=%0d", t, renew_seen, exp_n);
    end
    renew_seen = 0;
  endtask

  initial begin
    tag = "R1";                       // reset state
    wait_cyc(3);
    rst_n = 1'b1;
    wait_cyc(3);
    count_check("R1", 0);

    tag = "R2"; renew_seen = 0;       // R9 tick spacing seen through expiry timing
    do_load(32'd5); wait_cyc(60);
    count_check("R3", 1);

    tag = "R3";
    do_load(32'd1); wait_cyc(20);
    count_check("R3", 0);
    do_load(32'd2); wait_cyc(30);
    count_check("R3", 1);

    tag = "R4";
    do_load(32'd100); wait_cyc(MAX * N + 10);
    count_check("R4", 1);
    do_load(32'hFFFF_FFFF); wait_cyc(MAX * N + 10);
    count_check("R4", 1);

    tag = "R5";
    do_load(32'd0); wait_cyc(30);
    count_check("R5", 0);

    tag = "R6";
    do_load(32'd6); wait_cyc(25);
    do_load(32'd3); wait_cyc(37);
    do_load(32'd4); wait_cyc(50);
    count_check("R6", 2);

    tag = "R7";
    do_load(32'd8); wait_cyc(23);
    @(negedge clk); link_down_i = 1'b1;
    @(negedge clk); link_down_i = 1'b0;
    tag = "R8"; wait_cyc(120);
    count_check("R8", 0);
    tag = "R7";
    do_load(32'd4); wait_cyc(27);     // after renewal, before expiry
    @(negedge clk); link_down_i = 1'b1; load_i = 1'b1; lease_i = 32'd9;
    @(negedge clk); link_down_i = 1'b0; load_i = 1'b0;
    tag = "R8"; wait_cyc(120);
    count_check("R7", 1);

    tag = "R8";
    do_load(32'd3); wait_cyc(100);
    count_check("R8", 1);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog (all requirements) actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule